// File: doc/BRIEF.md
# UART Flow-Control and Status Unit

This unit is the control and status logic that sits around one UART channel. It keeps the sticky receive error flags and a combined error flag. It tracks the transmit buffer-empty and transmit-complete conditions and raises a maskable transmit interrupt. It decides when a byte written into the transmit holding buffer is handed to the serial shifter. That hand-off can be held back by the clear-to-send input.

On the receive side, the unit drives a request-to-send output. After each received frame the output is raised. It is lowered again once a programmable number of bit-time ticks have passed. The countdown pauses while another incoming frame is in progress. Baud generation and the shift registers are outside the unit. The receiver reports start, stop and error events as one-cycle strobes. The transmitter reports the end of each stop bit as a strobe and takes each byte on a one-cycle load pulse.

Software uses a small register port with a registered read path. The register map is as follows:
- Address 0 is status, read-only. Its bits are [0] parity error, [1] framing error, [2] overrun error, [3] any error, [4] buffer empty, [5] transmit complete.
- Address 1 is control. Its bits are [0] transmit enable, [1] CTS gating, [2] interrupt source (0 = buffer empty, 1 = transmit complete) and [3] interrupt enable. Bit 4 is the transmit-initialize action and bit 5 is the receive-initialize action. Both action bits read back as 0.
- Address 2 holds the interrupt request in bit 0.
- Address 3 holds the RTS reload value.
- Address 4 is the transmit buffer, write-only.

Top module: `uart_flow_status`

## Requirements
- R1: A strobe on rx_par_err, rx_frm_err or rx_ovr_err sets status bit 0, 1 or 2 respectively, together with status bit 3 (any error). Each bit then holds until it is cleared.
- R2: Any read of address 0 returns the flags as they were, then clears status bits 0 to 3 one cycle later. This happens for every rd_en access at that address, whatever its purpose. A strobe in the same cycle as the clear wins.
- R3: After reset, status reads 0x30, the RTS reload reads 0x80, and rts, irq and tx_load are 0.
- R4: The unit transfers the buffer when all of these hold: transmit enable is 1, the buffer is full and the shifter is idle. When that happens, tx_load pulses for one cycle on the next edge with the buffered byte on tx_data. Buffer-empty is set and transmit-complete is cleared.
- R5: While CTS gating is 1 and cts_n is high, no transfer takes place. The transfer happens once cts_n is low.
- R6: When rts is low, an rx_stop strobe raises rts and loads the counter from the reload value. Each bit_tick then counts down. rts falls on the tick that takes the count to zero, and a reload value of 0 or 1 falls on the first tick.
- R7: While rts is high, rx_start freezes the count and rts stays high. The next rx_stop resumes the count without reloading it.
- R8: Writing control bit 5 (receive initialize) sets the reload value to 0x80, drives rts low and ends any frame in progress.
- R9: Writing control bit 4 (transmit initialize) sets buffer-empty, transmit-complete and the interrupt request to 1. It also marks the shifter idle and clears status bits 0 to 3.
- R10: The interrupt request is set on a 0-to-1 change of the selected flag. It is also set by a control write that turns transmit enable from 0 to 1 while the newly selected flag is already 1.
- R11: irq equals the interrupt request ANDed with interrupt enable. Writing address 2 with bit 0 at 0 clears the request, and a set event in the same cycle wins.
- R12: A tx_stop_end strobe sets transmit-complete when the buffer is empty and is not being written in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, updated the cycle after rd_en |
| cts_n | input | 1 | Clear-to-send, active low |
| rts | output | 1 | Request-to-send hold (1 = hold off the far end) |
| rx_start | input | 1 | Receiver start-bit strobe |
| rx_stop | input | 1 | Receiver final stop-bit strobe |
| rx_par_err | input | 1 | Parity error strobe |
| rx_frm_err | input | 1 | Framing error strobe |
| rx_ovr_err | input | 1 | Overrun error strobe |
| bit_tick | input | 1 | One pulse per bit time |
| tx_load | output | 1 | One-cycle pulse moving the buffer into the shifter |
| tx_data | output | DATA_W | Byte handed to the shifter |
| tx_stop_end | input | 1 | End of the transmitted stop bit |
| irq | output | 1 | Transmit interrupt request output |

## Verification
The assertions assume the following about the inputs:
- rx_start and rx_stop never pulse in the same cycle.
- tx_stop_end arrives only while a byte is in the shifter.
- rd_en and wr_en are never active together.

The random stimulus follows these rules. It draws at most one of the two receiver frame strobes per cycle. It issues tx_stop_end only when the bench's own model holds the shifter busy. It picks one register access per cycle at most. Directed sequences cover the clear-to-send hold, the RTS freeze across a frame, and the two initialize actions.

// File: rtl/uart_cs_pkg.sv
package uart_cs_pkg;
  localparam int A_STATUS = 0;
  localparam int A_CTRL   = 1;
  localparam int A_IRQ    = 2;
  localparam int A_RTS    = 3;
  localparam int A_TXBUF  = 4;
  localparam int C_TX_EN   = 0;
  localparam int C_CTS     = 1;
  localparam int C_SEL     = 2;
  localparam int C_IRQ_EN  = 3;
  localparam int C_TX_INIT = 4;
  localparam int C_RX_INIT = 5;
  localparam int N_ERR     = 3;
endpackage

// File: rtl/ucs_err_flags.sv
module ucs_err_flags
  import uart_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [N_ERR-1:0] set,
  output logic [N_ERR-1:0] err,
  output logic             any_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err     <= '0;
      any_err <= 1'b0;
    end else begin
      err     <= (err & {N_ERR{~clr}}) | set;
      any_err <= (any_err & ~clr) | (|set);
    end
  end

  AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (rst)
    any_err == (|err)); // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr && set == '0) |=> (err == '0 && !any_err)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!clr && err[0]) |=> err[0]); // R1
endmodule

// File: rtl/ucs_rts_pacer.sv
module ucs_rts_pacer #(
  parameter int              CNT_W     = 8,
  parameter logic [CNT_W-1:0] RELOAD_RST = 8'h80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wdata,
  input  logic             rx_init,
  input  logic             rx_start,
  input  logic             rx_stop,
  input  logic             bit_tick,
  output logic             rts,
  output logic [CNT_W-1:0] reload
);
  logic [CNT_W-1:0] cnt_q;
  logic             in_frame_q;
  logic             count_now;

  assign count_now = rts && bit_tick && !in_frame_q && !rx_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload     <= RELOAD_RST;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      rts        <= 1'b0;
    end else if (rx_init) begin
      reload     <= RELOAD_RST;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      rts        <= 1'b0;
    end else begin
      if (wr_reload) reload <= wdata;
      if (rx_start)     in_frame_q <= 1'b1;
      else if (rx_stop) in_frame_q <= 1'b0;
      if (!rts && rx_stop) begin
        rts   <= 1'b1;
        cnt_q <= reload;
      end else if (count_now) begin
        if (cnt_q <= CNT_W'(1)) begin
          rts   <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  AST_RTS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (rts && in_frame_q && !rx_init) |=> (rts && $stable(cnt_q))); // R7
  AST_RTS_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!rts && !rx_stop) |=> !rts); // R6
  AST_RX_INIT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    rx_init |=> (reload == RELOAD_RST && !rts)); // R8
endmodule

// File: rtl/ucs_tx_ctl.sv
module ucs_tx_ctl
  import uart_cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_buf,
  input  logic              wr_irq,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_init,
  input  logic              cts_n,
  input  logic              stop_end,
  output logic              tx_en,
  output logic              cts_gate,
  output logic              irq_sel,
  output logic              irq_en,
  output logic              empty,
  output logic              done,
  output logic              req,
  output logic              irq,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data
);
  logic              busy_q;
  logic [DATA_W-1:0] buf_q;
  logic              do_xfer, empty_d, done_d, en_set, req_set;

  always_comb begin
    do_xfer = !tx_init && tx_en && !empty && !busy_q && (!cts_gate || !cts_n);
    empty_d = tx_init ? 1'b1 : wr_buf ? 1'b0 : do_xfer ? 1'b1 : empty;
    done_d  = tx_init ? 1'b1 : do_xfer ? 1'b0 :
              (stop_end && empty && !wr_buf) ? 1'b1 : done;
    en_set  = wr_ctrl && wdata[C_TX_EN] && !tx_en &&
              (wdata[C_SEL] ? done : empty);
    req_set = tx_init || en_set ||
              (irq_sel ? (done_d && !done) : (empty_d && !empty));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en    <= 1'b0;
      cts_gate <= 1'b0;
      irq_sel  <= 1'b0;
      irq_en   <= 1'b0;
      busy_q   <= 1'b0;
      empty    <= 1'b1;
      done     <= 1'b1;
      req      <= 1'b0;
      tx_load  <= 1'b0;
      buf_q    <= '0;
      tx_data  <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_en    <= wdata[C_TX_EN];
        cts_gate <= wdata[C_CTS];
        irq_sel  <= wdata[C_SEL];
        irq_en   <= wdata[C_IRQ_EN];
      end
      if (wr_buf) buf_q <= wdata;
      empty   <= empty_d;
      done    <= done_d;
      tx_load <= do_xfer;
      if (do_xfer) tx_data <= buf_q;
      if (tx_init)       busy_q <= 1'b0;
      else if (do_xfer)  busy_q <= 1'b1;
      else if (stop_end) busy_q <= 1'b0;
      if (req_set)                        req <= 1'b1;
      else if (wr_irq && !wdata[0])       req <= 1'b0;
    end
  end

  assign irq = req & irq_en;

  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(!cts_gate || !cts_n)); // R5
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> (empty || $past(wr_buf))); // R4
  AST_INIT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    tx_init |=> (empty && done && req)); // R9
  AST_DONE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!done && !tx_init) |=> (!done || $past(empty))); // R12
endmodule

// File: rtl/uart_flow_status.sv
module uart_flow_status
  import uart_cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int RTS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cts_n,
  output logic              rts,
  input  logic              rx_start,
  input  logic              rx_stop,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_ovr_err,
  input  logic              bit_tick,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_stop_end,
  output logic              irq
);
  localparam logic [RTS_W-1:0] RELOAD_RST = RTS_W'(8'h80);

  logic wr_ctrl, wr_buf, wr_irq, wr_rts, rd_stat, tx_init, rx_init;
  logic [N_ERR-1:0] err;
  logic any_err, tx_en, cts_gate, irq_sel, irq_en, empty, done, req;
  logic [RTS_W-1:0] reload;

  assign wr_ctrl = wr_en && addr == ADDR_W'(A_CTRL);
  assign wr_buf  = wr_en && addr == ADDR_W'(A_TXBUF);
  assign wr_irq  = wr_en && addr == ADDR_W'(A_IRQ);
  assign wr_rts  = wr_en && addr == ADDR_W'(A_RTS);
  assign rd_stat = rd_en && addr == ADDR_W'(A_STATUS);
  assign tx_init = wr_ctrl && wdata[C_TX_INIT];
  assign rx_init = wr_ctrl && wdata[C_RX_INIT];

  ucs_err_flags u_err (
    .clk(clk), .rst(rst), .clr(rd_stat || tx_init),
    .set({rx_ovr_err, rx_frm_err, rx_par_err}),
    .err(err), .any_err(any_err)
  );

  ucs_tx_ctl #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_buf(wr_buf),
    .wr_irq(wr_irq), .wdata(wdata), .tx_init(tx_init), .cts_n(cts_n),
    .stop_end(tx_stop_end), .tx_en(tx_en), .cts_gate(cts_gate),
    .irq_sel(irq_sel), .irq_en(irq_en), .empty(empty), .done(done),
    .req(req), .irq(irq), .tx_load(tx_load), .tx_data(tx_data)
  );

  ucs_rts_pacer #(.CNT_W(RTS_W), .RELOAD_RST(RELOAD_RST)) u_rts (
    .clk(clk), .rst(rst), .wr_reload(wr_rts), .wdata(wdata[RTS_W-1:0]),
    .rx_init(rx_init), .rx_start(rx_start), .rx_stop(rx_stop),
    .bit_tick(bit_tick), .rts(rts), .reload(reload)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(A_STATUS): rdata <= DATA_W'({done, empty, any_err, err});
        ADDR_W'(A_CTRL):   rdata <= DATA_W'({irq_en, irq_sel, cts_gate, tx_en});
        ADDR_W'(A_IRQ):    rdata <= DATA_W'(req);
        ADDR_W'(A_RTS):    rdata <= DATA_W'(reload);
        default:           rdata <= '0;
      endcase
    end
  end

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq); // R11
endmodule

// File: tb/tb_uart_flow_status.sv
module tb_uart_flow_status;
  logic clk = 1'b0, rst = 1'b1;
  logic rd = 0, wr = 0, cts_n = 0, rxs = 0, rxp = 0, pe = 0, fe = 0, oe = 0, tick = 0, se = 0;
  logic [2:0] addr = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdata, tx_data;
  logic rts, tx_load, irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model state
  bit m_pe, m_fe, m_oe, m_any, m_en, m_cts, m_sel, m_ien, m_busy, m_empty, m_done, m_req, m_load;
  bit m_rts, m_inf;
  int m_cnt, m_reload;
  logic [7:0] m_buf, m_txd, m_rdata;

  always #5 clk = ~clk;

  uart_flow_status dut (
    .clk(clk), .rst(rst), .rd_en(rd), .wr_en(wr), .addr(addr), .wdata(wd),
    .rdata(rdata), .cts_n(cts_n), .rts(rts), .rx_start(rxs), .rx_stop(rxp),
    .rx_par_err(pe), .rx_frm_err(fe), .rx_ovr_err(oe), .bit_tick(tick),
    .tx_load(tx_load), .tx_data(tx_data), .tx_stop_end(se), .irq(irq)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    {m_pe, m_fe, m_oe, m_any, m_en, m_cts, m_sel, m_ien, m_busy, m_req, m_load} = '0;
    m_empty = 1; m_done = 1; m_rts = 0; m_inf = 0; m_cnt = 0; m_reload = 8'h80;
    m_buf = 0; m_txd = 0; m_rdata = 0;
  endtask

  function automatic logic [7:0] status_val();
    return {2'b00, m_done, m_empty, m_any, m_oe, m_fe, m_pe};
  endfunction

  // one clock: model next state from inputs, edge, then compare
  task automatic cyc();
    bit wctl, wbuf, wirq, wrts, clr, tinit, rinit, xfer, e_n, d_n, eset, rset, cnt_now;
    int cnt_n, rel_n;
    bit rts_n, inf_n, busy_n, req_n;
    logic [7:0] rd_n;
    wctl = wr && addr == 1; wbuf = wr && addr == 4; wirq = wr && addr == 2; wrts = wr && addr == 3;
    tinit = wctl && wd[4]; rinit = wctl && wd[5];
    clr = (rd && addr == 0) || tinit;
    rd_n = m_rdata;
    if (rd) case (addr)
      0: rd_n = status_val();
      1: rd_n = {4'b0, m_ien, m_sel, m_cts, m_en};
      2: rd_n = {7'b0, m_req};
      3: rd_n = 8'(m_reload);
      default: rd_n = 0;
    endcase
    xfer = !tinit && m_en && !m_empty && !m_busy && (!m_cts || !cts_n);
    e_n = tinit ? 1 : wbuf ? 0 : xfer ? 1 : m_empty;
    d_n = tinit ? 1 : xfer ? 0 : (se && m_empty && !wbuf) ? 1 : m_done;
    busy_n = tinit ? 0 : xfer ? 1 : se ? 0 : m_busy;
    eset = wctl && wd[0] && !m_en && (wd[2] ? m_done : m_empty);
    rset = tinit || eset || (m_sel ? (d_n && !m_done) : (e_n && !m_empty));
    req_n = rset ? 1 : (wirq && !wd[0]) ? 0 : m_req;
    rts_n = m_rts; cnt_n = m_cnt; rel_n = m_reload; inf_n = m_inf;
    if (rinit) begin rts_n = 0; cnt_n = 0; rel_n = 8'h80; inf_n = 0; end
    else begin
      if (wrts) rel_n = wd;
      if (rxs) inf_n = 1; else if (rxp) inf_n = 0;
      cnt_now = m_rts && tick && !m_inf && !rxs;
      if (!m_rts && rxp) begin rts_n = 1; cnt_n = m_reload; end
      else if (cnt_now) begin
        if (m_cnt <= 1) begin rts_n = 0; cnt_n = 0; end else cnt_n = m_cnt - 1;
      end
    end
    @(posedge clk);
    m_pe = (m_pe && !clr) || pe; m_fe = (m_fe && !clr) || fe; m_oe = (m_oe && !clr) || oe;
    m_any = (m_any && !clr) || pe || fe || oe;
    if (wctl) begin m_en = wd[0]; m_cts = wd[1]; m_sel = wd[2]; m_ien = wd[3]; end
    if (xfer) m_txd = m_buf;
    if (wbuf) m_buf = wd;
    m_load = xfer; m_empty = e_n; m_done = d_n; m_busy = busy_n; m_req = req_n;
    m_rts = rts_n; m_cnt = cnt_n; m_reload = rel_n; m_inf = inf_n; m_rdata = rd_n;
    @(negedge clk);
    check("R6 rts", rts, m_rts);
    check("R4 tx_load", tx_load, m_load);
    if (m_load) check("R4 tx_data", tx_data, m_txd);
    check("R11 irq", irq, m_req && m_ien);
    check("R2 rdata", rdata, m_rdata);
  endtask

  task automatic idle();
    rd = 0; wr = 0; rxs = 0; rxp = 0; pe = 0; fe = 0; oe = 0; tick = 0; se = 0;
  endtask

  task automatic do_read(logic [2:0] a);
    idle(); rd = 1; addr = a; cyc(); rd = 0;
  endtask

  task automatic do_write(logic [2:0] a, logic [7:0] d);
    idle(); wr = 1; addr = a; wd = d; cyc(); wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R3 reset state
    check("R3 rts", rts, 0); check("R3 irq", irq, 0); check("R3 tx_load", tx_load, 0);
    do_read(0); check("R3 status", rdata, 8'h30);
    do_read(3); check("R3 reload", rdata, 8'h80);
    // R1 / R2 error flags
    idle(); pe = 1; cyc(); idle(); oe = 1; cyc(); idle();
    do_read(0); check("R1 status", rdata, 8'h3D);
    do_read(0); check("R2 cleared", rdata, 8'h30);
    // R10 enable with empty selected, R11 clear
    do_write(1, 8'h0B); check("R10 irq on enable", irq, 1);
    do_write(2, 8'h00); check("R11 irq cleared", irq, 0);
    // R5 CTS hold
    cts_n = 1; do_write(4, 8'hA5);
    idle(); repeat (4) begin cyc(); check("R5 no load", tx_load, 0); end
    cts_n = 0; cyc();
    check("R4 load", tx_load, 1); check("R4 data", tx_data, 8'hA5);
    check("R10 irq on empty", irq, 1);
    idle(); se = 1; cyc(); idle();
    do_read(0); check("R12 complete", rdata, 8'h30);
    // R6 / R7 RTS pacing
    do_write(3, 8'h03);
    idle(); rxp = 1; cyc(); check("R6 rts up", rts, 1);
    idle(); tick = 1; cyc(); idle(); rxs = 1; cyc();
    idle(); tick = 1; repeat (5) begin cyc(); check("R7 frozen", rts, 1); end
    idle(); rxp = 1; cyc(); check("R7 still high", rts, 1);
    idle(); tick = 1; cyc(); check("R7 resumed", rts, 1);
    cyc(); check("R6 rts low", rts, 0); idle();
    // R8 receive init
    do_write(3, 8'h10); do_write(1, 8'h20);
    do_read(3); check("R8 reload", rdata, 8'h80);
    // R9 transmit init
    idle(); fe = 1; cyc();
    do_write(2, 8'h00); do_write(1, 8'h18);
    check("R9 irq", irq, 1);
    do_read(0); check("R9 status", rdata, 8'h30);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      idle();
      r = $urandom_range(0, 99);
      if (r < 20) begin rd = 1; addr = 3'($urandom_range(0, 4)); end
      else if (r < 40) begin
        wr = 1; addr = 3'($urandom_range(0, 4)); wd = 8'($urandom);
        if (addr == 1) begin
          wd[4] = ($urandom_range(0, 9) == 0);
          wd[5] = ($urandom_range(0, 9) == 0);
        end
      end
      if ($urandom_range(0, 19) == 0) cts_n = ~cts_n;
      pe = ($urandom_range(0, 19) == 0); fe = ($urandom_range(0, 19) == 0);
      oe = ($urandom_range(0, 19) == 0);
      if (!m_inf && $urandom_range(0, 19) == 0) rxs = 1;
      else if ($urandom_range(0, 9) == 0) rxp = 1;
      tick = ($urandom_range(0, 2) == 0);
      se = m_busy && ($urandom_range(0, 4) == 0);
      cyc();
    end
    idle(); cyc();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule